// File: doc/BRIEF.md
# Trigger Time-Stamp Unit

The unit keeps a running timebase split into a whole-second count and a sub-second tick count, and stamps every trigger with it. At the default setting a tick lasts 8 ns, so there are 125,000,000 ticks in one second. Software can load either count at any time and read both back. When the tick count reaches its last value it returns to zero and the second count moves on by one.

When a trigger pulse arrives, the unit takes a snapshot of four 32-bit words: a metadata word that carries the trigger source code, the seconds, the ticks, and a fine-time word taken from an input. The snapshot goes into a set of holding registers that software reads. The same snapshot is also sent as a four-beat word stream toward the sample memory, so the copy stored with the samples is the same as the copy in the registers. After a run of several shots, the registers hold the stamp of the last shot.

Top module: `trig_stamp_unit`

## Requirements
- R1: After reset, both counters, all four tag words, `tag_valid` and `strm_valid` are zero.
- R2: With no write pending, the tick count rises by one on each clock and the second count stays the same, as long as the tick count is below TICKS_PER_SEC-1.
- R3: On the clock that follows a tick count of TICKS_PER_SEC-1, the tick count becomes 0 and the second count rises by one in that same clock.
- R4: A write to either counter shows on the next clock and overrides that counter's own increment or wrap. A second-count write made while the tick count sits at its terminal value wins over the carry.
- R5: A tick count at or above TICKS_PER_SEC-1 counts as terminal. This also applies to a value loaded by software, so the next clock gives tick 0 and a carry. A tick-count write made at the terminal value still lets the carry reach the second count.
- R6: On the clock where `trig_in` is high, the tag words take the second and tick counts present before that clock edge, and `tag_fine` takes `fine_in`. A counter write in the same cycle does not change the captured value.
- R7: The metadata word holds `trig_src` zero-extended into bits [SRC_W-1:0] and zeros in all other bits.
- R8: `tag_valid` is high for exactly the one clock that follows each capture.
- R9: Starting the clock after a capture, the stream sends four beats on consecutive clocks with `strm_idx` 0,1,2,3 and words metadata, seconds, ticks, fine. `strm_last` marks beat 3, and `strm_valid` then drops.
- R10: Every streamed word equals the matching register word of the same capture.
- R11: The tag registers hold their value between triggers, so after several triggers they show the last one.
- R12: A trigger that arrives while a stream is running restarts the stream at beat 0 with the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (one tick per cycle) |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_wr_en | input | 1 | Load the second count |
| sec_wr_data | input | 32 | Value for the second count |
| crs_wr_en | input | 1 | Load the tick count |
| crs_wr_data | input | 32 | Value for the tick count |
| trig_in | input | 1 | Trigger pulse, one cycle per event |
| trig_src | input | SRC_W | Trigger source code |
| fine_in | input | 32 | Fine-time word captured with the tag |
| sec_now | output | 32 | Present second count |
| crs_now | output | 32 | Present tick count |
| tag_meta | output | 32 | Last tag: metadata word |
| tag_sec | output | 32 | Last tag: seconds |
| tag_crs | output | 32 | Last tag: ticks |
| tag_fine | output | 32 | Last tag: fine word |
| tag_valid | output | 1 | One-clock strobe for a new tag |
| strm_valid | output | 1 | Stream beat valid |
| strm_idx | output | 2 | Stream beat number |
| strm_last | output | 1 | Final stream beat |
| strm_word | output | 32 | Stream beat data |

## Verification
The hardest case to reach is the carry from ticks into seconds. At the default rate a natural rollover takes 125 million cycles. The bench instead loads the tick count to just below the terminal value and then watches the wrap over the next few clocks. It then loads writes into the terminal cycle itself to test the priority rules. It also fires a trigger in the same cycle as a counter write, and a second trigger while a stream is running, to cover the capture-order and restart cases.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BEATS  = 4;
    localparam int unsigned IDX_W  = $clog2(BEATS);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t meta;
        word_t sec;
        word_t crs;
        word_t fine;
    } tag_t;

    typedef struct packed {
        word_t sec;
        word_t crs;
    } tbase_t;

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
    } strm_t;
endpackage

// File: rtl/tsu_timebase.sv
module tsu_timebase
    import tsu_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 125000000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sec_we,
    input  word_t sec_wd,
    input  logic  crs_we,
    input  word_t crs_wd,
    output word_t sec_o,
    output word_t crs_o
);
    localparam word_t TERMINAL = word_t'(TICKS_PER_SEC - 1);

    tbase_t tb_d, tb_q;
    logic   at_end;

    always_comb begin
        tb_d   = tb_q;
        at_end = (tb_q.crs >= TERMINAL);
        // tick count: write beats increment/wrap
        if (crs_we)
            tb_d.crs = crs_wd;
        else if (at_end)
            tb_d.crs = '0;
        else
            tb_d.crs = tb_q.crs + word_t'(1);
        // second count: write beats carry
        if (sec_we)
            tb_d.sec = sec_wd;
        else if (at_end)
            tb_d.sec = tb_q.sec + word_t'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign sec_o = tb_q.sec;
    assign crs_o = tb_q.crs;
endmodule

// File: rtl/tsu_capture.sv
module tsu_capture
    import tsu_pkg::*;
#(
    parameter int unsigned SRC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [SRC_W-1:0] src,
    input  word_t            fine,
    input  word_t            sec,
    input  word_t            crs,
    output tag_t             tag_o,
    output logic             valid_o
);
    tag_t tag_d, tag_q;
    logic valid_d, valid_q;

    always_comb begin
        tag_d   = tag_q;
        valid_d = trig;
        if (trig) begin
            tag_d.meta = word_t'(src);
            tag_d.sec  = sec;
            tag_d.crs  = crs;
            tag_d.fine = fine;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            tag_q   <= tag_d;
            valid_q <= valid_d;
        end
    end

    assign tag_o   = tag_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/tsu_stream.sv
module tsu_stream
    import tsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  tag_t             tag,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o,
    output word_t            word_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    strm_t st_d, st_q;
    word_t beat [BEATS];

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
        end else if (st_q.active) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.active = 1'b0;
                st_d.idx    = '0;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // beat order: meta, seconds, ticks, fine
    assign beat[0] = tag.meta;
    assign beat[1] = tag.sec;
    assign beat[2] = tag.crs;
    assign beat[3] = tag.fine;

    assign valid_o = st_q.active;
    assign idx_o   = st_q.idx;
    assign last_o  = st_q.active && (st_q.idx == LAST_IDX);
    assign word_o  = st_q.active ? beat[st_q.idx] : '0;
endmodule

// File: rtl/trig_stamp_unit.sv
module trig_stamp_unit
    import tsu_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 125000000,
    parameter int unsigned SRC_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_wr_en,
    input  logic [31:0]      sec_wr_data,
    input  logic             crs_wr_en,
    input  logic [31:0]      crs_wr_data,
    input  logic             trig_in,
    input  logic [SRC_W-1:0] trig_src,
    input  logic [31:0]      fine_in,
    output logic [31:0]      sec_now,
    output logic [31:0]      crs_now,
    output logic [31:0]      tag_meta,
    output logic [31:0]      tag_sec,
    output logic [31:0]      tag_crs,
    output logic [31:0]      tag_fine,
    output logic             tag_valid,
    output logic             strm_valid,
    output logic [1:0]       strm_idx,
    output logic             strm_last,
    output logic [31:0]      strm_word
);
    tag_t tag;

    tsu_timebase #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tbase (
        .clk    (clk),
        .rst_n  (rst_n),
        .sec_we (sec_wr_en),
        .sec_wd (sec_wr_data),
        .crs_we (crs_wr_en),
        .crs_wd (crs_wr_data),
        .sec_o  (sec_now),
        .crs_o  (crs_now)
    );

    tsu_capture #(.SRC_W(SRC_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig_in),
        .src     (trig_src),
        .fine    (fine_in),
        .sec     (sec_now),
        .crs     (crs_now),
        .tag_o   (tag),
        .valid_o (tag_valid)
    );

    tsu_stream u_strm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (trig_in),
        .tag     (tag),
        .valid_o (strm_valid),
        .idx_o   (strm_idx),
        .last_o  (strm_last),
        .word_o  (strm_word)
    );

    assign tag_meta = tag.meta;
    assign tag_sec  = tag.sec;
    assign tag_crs  = tag.crs;
    assign tag_fine = tag.fine;
endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
    parameter int unsigned TICKS_PER_SEC = 125000000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sec_wr_en,
    input logic [31:0] sec_wr_data,
    input logic        crs_wr_en,
    input logic [31:0] crs_wr_data,
    input logic        trig_in,
    input logic [31:0] sec_now,
    input logic [31:0] crs_now,
    input logic [31:0] tag_sec,
    input logic [31:0] tag_crs,
    input logic        tag_valid,
    input logic        strm_valid,
    input logic        strm_last
);
    localparam logic [31:0] TERM = 32'(TICKS_PER_SEC - 1);

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!crs_wr_en && crs_now < TERM) |=> crs_now == $past(crs_now) + 32'd1); // R2
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_wr_en && crs_now < TERM) |=> $stable(sec_now)); // R2
    AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_wr_en && crs_now >= TERM) |=> sec_now == $past(sec_now) + 32'd1); // R3
    AST_SEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr_en |=> sec_now == $past(sec_wr_data)); // R4
    AST_TICK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        crs_wr_en |=> crs_now == $past(crs_wr_data)); // R4
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_in |=> (tag_sec == $past(sec_now) && tag_crs == $past(crs_now))); // R6
    AST_STROBE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        trig_in |=> tag_valid); // R8
    AST_STROBE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_in |=> !tag_valid); // R8
    AST_STREAM_GO: assert property (@(posedge clk) disable iff (!rst_n)
        trig_in |=> (strm_valid && !strm_last)); // R9
    AST_STREAM_END: assert property (@(posedge clk) disable iff (!rst_n)
        (strm_last && !trig_in) |=> !strm_valid); // R9
    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_in |=> ($stable(tag_sec) && $stable(tag_crs))); // R11
endmodule

bind trig_stamp_unit tsu_checker #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_wr_en   (sec_wr_en),
    .sec_wr_data (sec_wr_data),
    .crs_wr_en   (crs_wr_en),
    .crs_wr_data (crs_wr_data),
    .trig_in     (trig_in),
    .sec_now     (sec_now),
    .crs_now     (crs_now),
    .tag_sec     (tag_sec),
    .tag_crs     (tag_crs),
    .tag_valid   (tag_valid),
    .strm_valid  (strm_valid),
    .strm_last   (strm_last)
);

// File: tb/trig_stamp_unit_test.sv
module trig_stamp_unit_test;
    localparam int unsigned T = 125000000;
    localparam logic [31:0] TERM = 32'(T - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_wr_en = 1'b0, crs_wr_en = 1'b0, trig_in = 1'b0;
    logic [31:0] sec_wr_data = '0, crs_wr_data = '0, fine_in = '0;
    logic [3:0]  trig_src = '0;
    logic [31:0] sec_now, crs_now, tag_meta, tag_sec, tag_crs, tag_fine, strm_word;
    logic        tag_valid, strm_valid, strm_last;
    logic [1:0]  strm_idx;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trig_stamp_unit uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_crs(input logic [31:0] v);
        @(negedge clk); crs_wr_en = 1'b1; crs_wr_data = v;
        @(negedge clk); crs_wr_en = 1'b0;
    endtask

    task automatic test_reset();
        chk("R1 sec", sec_now, 0);   chk("R1 crs", crs_now, 0);
        chk("R1 meta", tag_meta, 0); chk("R1 tsec", tag_sec, 0);
        chk("R1 tcrs", tag_crs, 0);  chk("R1 fine", tag_fine, 0);
        chk("R1 valid", {31'd0, tag_valid}, 0);
        chk("R1 strm", {31'd0, strm_valid}, 0);
    endtask

    task automatic test_count();
        logic [31:0] c0, s0;
        c0 = crs_now; s0 = sec_now;
        repeat (5) @(negedge clk);
        chk("R2 tick", crs_now, c0 + 5);
        chk("R2 sec hold", sec_now, s0);
    endtask

    task automatic test_wrap();
        logic [31:0] s0;
        wr_crs(TERM - 2);
        s0 = sec_now;
        chk("R4 load", crs_now, TERM - 2);
        @(negedge clk); chk("R3 pre", crs_now, TERM - 1);
        @(negedge clk); chk("R3 term", crs_now, TERM); chk("R3 no carry yet", sec_now, s0);
        @(negedge clk); chk("R3 wrap", crs_now, 0);    chk("R3 carry", sec_now, s0 + 1);
    endtask

    task automatic test_priority();
        logic [31:0] s0;
        @(negedge clk);
        crs_wr_en = 1'b1; crs_wr_data = TERM; sec_wr_en = 1'b1; sec_wr_data = 32'd5;
        @(negedge clk);
        crs_wr_en = 1'b0; sec_wr_data = 32'h100;
        chk("R4 both crs", crs_now, TERM); chk("R4 both sec", sec_now, 5);
        @(negedge clk);
        sec_wr_en = 1'b0;
        chk("R4 sec write beats carry", sec_now, 32'h100);
        chk("R4 wrap with sec write", crs_now, 0);
        wr_crs(TERM);
        s0 = sec_now;
        crs_wr_en = 1'b1; crs_wr_data = 32'd7;
        @(negedge clk);
        crs_wr_en = 1'b0;
        chk("R5 tick write", crs_now, 7);
        chk("R5 carry kept", sec_now, s0 + 1);
        wr_crs(32'hFFFF_FFF0);
        s0 = sec_now;
        @(negedge clk);
        chk("R5 over range wraps", crs_now, 0);
        chk("R5 over range carry", sec_now, s0 + 1);
    endtask

    // fires one trigger from a negedge, returns expected sec/crs
    task automatic fire(input logic [3:0] src, input logic [31:0] fine,
                        output logic [31:0] es, output logic [31:0] ec);
        es = sec_now; ec = crs_now;
        trig_in = 1'b1; trig_src = src; fine_in = fine;
        @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic test_capture();
        logic [31:0] es, ec;
        @(negedge clk);
        fire(4'hF, 32'hABC, es, ec);
        chk("R7 meta", tag_meta, 32'h0000_000F);
        chk("R6 sec", tag_sec, es); chk("R6 crs", tag_crs, ec);
        chk("R6 fine", tag_fine, 32'hABC);
        chk("R8 strobe", {31'd0, tag_valid}, 1);
        chk("R9 b0 valid", {31'd0, strm_valid}, 1);
        chk("R9 b0 idx", {30'd0, strm_idx}, 0);
        chk("R10 b0", strm_word, tag_meta);
        @(negedge clk);
        chk("R8 one clock", {31'd0, tag_valid}, 0);
        chk("R9 b1 idx", {30'd0, strm_idx}, 1); chk("R10 b1", strm_word, es);
        @(negedge clk);
        chk("R9 b2 idx", {30'd0, strm_idx}, 2); chk("R10 b2", strm_word, ec);
        @(negedge clk);
        chk("R9 b3 idx", {30'd0, strm_idx}, 3); chk("R10 b3", strm_word, 32'hABC);
        chk("R9 last", {31'd0, strm_last}, 1);
        @(negedge clk);
        chk("R9 end", {31'd0, strm_valid}, 0);
        repeat (3) @(negedge clk);
        chk("R11 hold sec", tag_sec, es); chk("R11 hold fine", tag_fine, 32'hABC);
    endtask

    task automatic test_multi();
        logic [31:0] es, ec;
        for (int i = 0; i < 3; i++) begin
            fire(4'(i + 1), 32'(i * 17), es, ec);
            repeat (6) @(negedge clk);
        end
        chk("R11 last meta", tag_meta, 3);
        chk("R11 last sec", tag_sec, es); chk("R11 last crs", tag_crs, ec);
        chk("R11 last fine", tag_fine, 34);
    endtask

    task automatic test_restart();
        logic [31:0] es, ec;
        fire(4'h2, 32'h1, es, ec);
        @(negedge clk);
        chk("R12 mid", {30'd0, strm_idx}, 1);
        fire(4'h9, 32'h55, es, ec);
        chk("R12 restart idx", {30'd0, strm_idx}, 0);
        chk("R12 restart word", strm_word, 9);
        @(negedge clk); chk("R12 new sec", strm_word, es);
        @(negedge clk); chk("R12 new crs", strm_word, ec);
        @(negedge clk); chk("R12 new fine", strm_word, 32'h55);
        @(negedge clk); chk("R12 end", {31'd0, strm_valid}, 0);
    endtask

    task automatic test_write_and_trig();
        logic [31:0] es, ec;
        sec_wr_en = 1'b1; sec_wr_data = 32'h77;
        fire(4'h1, 32'h0, es, ec);
        sec_wr_en = 1'b0;
        chk("R6 pre-write seconds", tag_sec, es);
        chk("R4 write landed", sec_now, 32'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_count();
        test_wrap();
        test_priority();
        test_capture();
        test_multi();
        test_restart();
        @(negedge clk);
        test_write_and_trig();
        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule